// File: doc/BRIEF.md
# Task-Switch Bookkeeping Controller

This controller keeps the control state behind a hardware task switch for a small table of task entries. Each entry holds a descriptor type code whose busy bit marks a task that is running or suspended inside a call chain. Each entry also holds a link selector naming the task that called it, and a saved copy of the nested-task flag. The controller itself holds the current task selector and the live nested-task flag. It does not move register contents and it does not check privilege levels.

A requester presents an operation (jump, call, interrupt through a task gate, or return), a target selector and, for interrupts, the gate type. One cycle later the controller pulses `done`. By then it has either moved to the new task, with all busy, link and flag updates applied, or it pulses `fault` and leaves every piece of state untouched. Busy checking refuses any attempt to enter a task that is already active, so no task can be re-entered recursively. Calls can still nest to any depth, and returns unwind that chain one level at a time. A read port exposes any entry's type code, link and saved flag.

Top module: `taskswitch_ctrl`

## Requirements
- R1: After reset the current selector is 0 and the nested flag is 0. Task 0 holds the busy type code and every other task holds the available code. All links and saved flags are 0.
- R2: Bit 1 of a type code is the busy bit. With WIDE_FORM=1 the available code is 0x9 and the busy code is 0xB. With WIDE_FORM=0 they are 0x1 and 0x3.
- R3: A request is taken on a rising edge with `req_valid` high. On that same edge `done` rises for exactly one cycle. `cur_sel` and `nt_flag` take their new values on that edge, and `fault` rises alongside `done` when the request is refused.
- R4: A jump (op 0) marks the target busy and marks the task being left available. It sets the nested flag to 0 and leaves all links unchanged.
- R5: A call (op 1) marks the target busy and leaves the outgoing task busy. It sets the nested flag to 1 and writes the outgoing selector into the target's link.
- R6: An interrupt (op 2) with gate type 0x5 behaves exactly like a call to `req_sel`. Any other gate type gives a fault.
- R7: A return (op 3) with the nested flag at 1 switches to the selector held in the current task's link. The task being left becomes available and its saved flag is cleared. The returned-to task stays busy.
- R8: A jump, call or interrupt whose target is already busy, including the current task itself, gives a fault and changes no state.
- R9: After a chain of calls, successive returns revisit the callers in reverse order, one level per return.
- R10: A return while the nested flag is 0 completes with `done` high and `fault` low, and changes no state.
- R11: A jump, call or interrupt selector at or above NUM_TASKS gives a fault and changes no state.
- R12: A jump, call or interrupt stores the live nested flag into the outgoing task's saved flag. A return loads the nested flag from the returned-to task's saved flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 jump, 1 call, 2 interrupt, 3 return |
| req_sel | input | SEL_W | Target selector (selector held in the gate for interrupts) |
| req_gate | input | 4 | Gate type for interrupt requests |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle refusal pulse, coincident with done |
| cur_sel | output | SEL_W | Current task selector |
| nt_flag | output | 1 | Live nested-task flag |
| rd_idx | input | clog2(NUM_TASKS) | Entry selected on the read port |
| rd_type | output | 4 | Type code of the selected entry |
| rd_link | output | SEL_W | Link selector of the selected entry |
| rd_nt | output | 1 | Saved nested flag of the selected entry |

## Verification
A busy bit left set by mistake shows up at the next jump or call to that task, which faults instead of switching. A busy bit wrongly cleared lets a busy task be entered again. A corrupted link or saved flag stays hidden until a return walks back through that entry, which may be many requests later. For that reason the bench reads every touched entry through the read port right after each switch, in the cycle after `done`, rather than waiting for a return to expose the error.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

   typedef enum logic [1:0] {
      OP_JMP  = 2'd0,
      OP_CALL = 2'd1,
      OP_INT  = 2'd2,
      OP_RET  = 2'd3
   } tsw_op_e;

   localparam logic [3:0] GATE_TASK = 4'h5;

endpackage

// File: rtl/tsw_table.sv
module tsw_table
   import tsw_pkg::*;
#(
   parameter int NUM_TASKS = 8,
   parameter int SEL_W     = 8,
   parameter bit WIDE_FORM = 1'b1,
   localparam int IDX_W    = $clog2(NUM_TASKS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                set_en,
   input  logic [IDX_W-1:0]                    set_idx,
   input  logic                                clr_en,
   input  logic [IDX_W-1:0]                    clr_idx,
   input  logic                                lnk_we,
   input  logic [IDX_W-1:0]                    lnk_idx,
   input  logic [SEL_W-1:0]                    lnk_val,
   input  logic                                snt_we,
   input  logic [IDX_W-1:0]                    snt_idx,
   input  logic                                snt_val,
   output logic [NUM_TASKS-1:0]                busy_o,
   output logic [NUM_TASKS-1:0][SEL_W-1:0]     link_o,
   output logic [NUM_TASKS-1:0]                snt_o,
   output logic [NUM_TASKS-1:0][3:0]           type_o
);

   for (genvar g = 0; g < NUM_TASKS; g++) begin : g_ent
      logic             busy_r;
      logic [SEL_W-1:0] link_r;
      logic             snt_r;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_r <= (g == 0);
            link_r <= '0;
            snt_r  <= 1'b0;
         end else begin
            if (set_en && set_idx == IDX_W'(g))
               busy_r <= 1'b1;
            else if (clr_en && clr_idx == IDX_W'(g))
               busy_r <= 1'b0;
            if (lnk_we && lnk_idx == IDX_W'(g))
               link_r <= lnk_val;
            if (snt_we && snt_idx == IDX_W'(g))
               snt_r <= snt_val;
         end
      end

      assign busy_o[g] = busy_r;
      assign link_o[g] = link_r;
      assign snt_o[g]  = snt_r;

      if (WIDE_FORM) begin : g_wide
         assign type_o[g] = {1'b1, 1'b0, busy_r, 1'b1};
      end else begin : g_narrow
         assign type_o[g] = {1'b0, 1'b0, busy_r, 1'b1};
      end
   end

   // R7/R4: one request never sets and clears the same entry
   a_r7_set_clr_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && clr_en) |-> (set_idx != clr_idx));

   // R1: at least one task is always active
   a_r1_some_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(busy_o) >= 1);

endmodule

// File: rtl/tsw_decide.sv
module tsw_decide
   import tsw_pkg::*;
#(
   parameter int NUM_TASKS = 8,
   parameter int SEL_W     = 8,
   localparam int IDX_W    = $clog2(NUM_TASKS)
) (
   input  tsw_op_e                             op,
   input  logic [SEL_W-1:0]                    req_sel,
   input  logic [3:0]                          gate,
   input  logic [SEL_W-1:0]                    cur_sel,
   input  logic                                nt,
   input  logic [NUM_TASKS-1:0]                busy_i,
   input  logic [NUM_TASKS-1:0][SEL_W-1:0]     link_i,
   input  logic [NUM_TASKS-1:0]                snt_i,
   output logic                                go,
   output logic                                flt,
   output logic [SEL_W-1:0]                    nxt_sel,
   output logic                                nxt_nt,
   output logic                                set_en,
   output logic [IDX_W-1:0]                    set_idx,
   output logic                                clr_en,
   output logic [IDX_W-1:0]                    clr_idx,
   output logic                                lnk_we,
   output logic [IDX_W-1:0]                    lnk_idx,
   output logic [SEL_W-1:0]                    lnk_val,
   output logic                                snt_we,
   output logic [IDX_W-1:0]                    snt_idx,
   output logic                                snt_val
);

   localparam logic [SEL_W-1:0] SEL_LIM = SEL_W'(NUM_TASKS);

   logic             tgt_in, ret_in, is_call, gate_bad;
   logic [IDX_W-1:0] tgt_idx, cur_idx, ret_idx;
   logic [SEL_W-1:0] ret_sel;

   assign tgt_in   = req_sel < SEL_LIM;
   assign tgt_idx  = req_sel[IDX_W-1:0];
   assign cur_idx  = cur_sel[IDX_W-1:0];
   assign ret_sel  = link_i[cur_idx];
   assign ret_in   = ret_sel < SEL_LIM;
   assign ret_idx  = ret_sel[IDX_W-1:0];
   assign is_call  = (op != OP_JMP);
   assign gate_bad = (op == OP_INT) && (gate != GATE_TASK);

   always_comb begin
      go      = 1'b0;
      flt     = 1'b0;
      nxt_sel = cur_sel;
      nxt_nt  = nt;
      set_en  = 1'b0;
      set_idx = tgt_idx;
      clr_en  = 1'b0;
      clr_idx = cur_idx;
      lnk_we  = 1'b0;
      lnk_idx = tgt_idx;
      lnk_val = cur_sel;
      snt_we  = 1'b0;
      snt_idx = cur_idx;
      snt_val = nt;
      if (op == OP_RET) begin
         if (nt) begin
            if (!ret_in || !busy_i[ret_idx]) begin
               flt = 1'b1;
            end else begin
               go      = 1'b1;
               nxt_sel = ret_sel;
               nxt_nt  = snt_i[ret_idx];
               clr_en  = 1'b1;
               snt_we  = 1'b1;
               snt_val = 1'b0;
            end
         end
      end else begin
         if (!tgt_in || gate_bad || busy_i[tgt_idx]) begin
            flt = 1'b1;
         end else begin
            go      = 1'b1;
            nxt_sel = req_sel;
            nxt_nt  = is_call;
            set_en  = 1'b1;
            clr_en  = !is_call;
            lnk_we  = is_call;
            snt_we  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/taskswitch_ctrl.sv
module taskswitch_ctrl
   import tsw_pkg::*;
#(
   parameter int NUM_TASKS = 8,
   parameter int SEL_W     = 8,
   parameter bit WIDE_FORM = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [1:0]                    req_op,
   input  logic [SEL_W-1:0]              req_sel,
   input  logic [3:0]                    req_gate,
   output logic                          done,
   output logic                          fault,
   output logic [SEL_W-1:0]              cur_sel,
   output logic                          nt_flag,
   input  logic [$clog2(NUM_TASKS)-1:0]  rd_idx,
   output logic [3:0]                    rd_type,
   output logic [SEL_W-1:0]              rd_link,
   output logic                          rd_nt
);

   localparam int IDX_W = $clog2(NUM_TASKS);
   localparam logic [SEL_W-1:0] SEL_LIM = SEL_W'(NUM_TASKS);

   if (NUM_TASKS < 2 || (1 << IDX_W) != NUM_TASKS) begin : g_chk_n
      $error("NUM_TASKS must be a power of two, at least 2");
   end
   if (SEL_W <= IDX_W) begin : g_chk_w
      $error("SEL_W must be wider than the table index");
   end

   tsw_op_e op;
   assign op = tsw_op_e'(req_op);

   logic [NUM_TASKS-1:0]            busy_v, snt_v;
   logic [NUM_TASKS-1:0][SEL_W-1:0] link_v;
   logic [NUM_TASKS-1:0][3:0]       type_v;

   logic             go, flt, nxt_nt;
   logic [SEL_W-1:0] nxt_sel, lnk_val;
   logic             set_en, clr_en, lnk_we, snt_we, snt_val;
   logic [IDX_W-1:0] set_idx, clr_idx, lnk_idx, snt_idx;
   logic             commit;

   tsw_decide #(.NUM_TASKS(NUM_TASKS), .SEL_W(SEL_W)) u_decide (
      .op(op), .req_sel(req_sel), .gate(req_gate),
      .cur_sel(cur_sel), .nt(nt_flag),
      .busy_i(busy_v), .link_i(link_v), .snt_i(snt_v),
      .go(go), .flt(flt), .nxt_sel(nxt_sel), .nxt_nt(nxt_nt),
      .set_en(set_en), .set_idx(set_idx), .clr_en(clr_en), .clr_idx(clr_idx),
      .lnk_we(lnk_we), .lnk_idx(lnk_idx), .lnk_val(lnk_val),
      .snt_we(snt_we), .snt_idx(snt_idx), .snt_val(snt_val)
   );

   assign commit = req_valid && go;

   tsw_table #(.NUM_TASKS(NUM_TASKS), .SEL_W(SEL_W), .WIDE_FORM(WIDE_FORM)) u_table (
      .clk(clk), .rst_n(rst_n),
      .set_en(commit && set_en), .set_idx(set_idx),
      .clr_en(commit && clr_en), .clr_idx(clr_idx),
      .lnk_we(commit && lnk_we), .lnk_idx(lnk_idx), .lnk_val(lnk_val),
      .snt_we(commit && snt_we), .snt_idx(snt_idx), .snt_val(snt_val),
      .busy_o(busy_v), .link_o(link_v), .snt_o(snt_v), .type_o(type_v)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_sel <= '0;
         nt_flag <= 1'b0;
         done    <= 1'b0;
         fault   <= 1'b0;
      end else begin
         done  <= req_valid;
         fault <= req_valid && flt;
         if (commit) begin
            cur_sel <= nxt_sel;
            nt_flag <= nxt_nt;
         end
      end
   end

   assign rd_type = type_v[rd_idx];
   assign rd_link = link_v[rd_idx];
   assign rd_nt   = snt_v[rd_idx];

   a_r3_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);

   a_r1_current_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_v[cur_sel[IDX_W-1:0]]);

   a_r5_call_sets_nt: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_CALL) |=> (fault || nt_flag));

   a_r4_jump_clears_nt: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_JMP) |=> (fault || !nt_flag));

   a_r8_refused_keeps_task: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> ($stable(cur_sel) && $stable(nt_flag)));

   a_r10_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op == OP_RET && !nt_flag) |=> (!fault && $stable(cur_sel)));

   a_r11_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && op != OP_RET && req_sel >= SEL_LIM) |=> fault);

endmodule

// File: tb/taskswitch_ctrl_test.sv
`timescale 1ns/1ps
module taskswitch_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [7:0] req_sel = 8'd0;
   logic [3:0] req_gate = 4'd0;
   logic [2:0] rd_idx = 3'd0;

   logic       done, fault, nt_flag, rd_nt;
   logic [7:0] cur_sel, rd_link;
   logic [3:0] rd_type;

   logic       n_done, n_fault, n_nt, n_rd_nt;
   logic [7:0] n_cur, n_rd_link;
   logic [3:0] n_rd_type;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   taskswitch_ctrl #(.NUM_TASKS(8), .SEL_W(8), .WIDE_FORM(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_sel(req_sel), .req_gate(req_gate), .done(done), .fault(fault),
      .cur_sel(cur_sel), .nt_flag(nt_flag), .rd_idx(rd_idx),
      .rd_type(rd_type), .rd_link(rd_link), .rd_nt(rd_nt)
   );

   taskswitch_ctrl #(.NUM_TASKS(8), .SEL_W(8), .WIDE_FORM(1'b0)) uut_n (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_sel(req_sel), .req_gate(req_gate), .done(n_done), .fault(n_fault),
      .cur_sel(n_cur), .nt_flag(n_nt), .rd_idx(rd_idx),
      .rd_type(n_rd_type), .rd_link(n_rd_link), .rd_nt(n_rd_nt)
   );

   localparam logic [1:0] JMP = 2'd0, CALL = 2'd1, INTR = 2'd2, RET = 2'd3;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] op, input logic [7:0] sel, input logic [3:0] gt);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_sel = sel; req_gate = gt;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic peek(input logic [2:0] idx);
      rd_idx = idx;
      #1;
   endtask

   task automatic outcome(input string req, input logic f,
                          input logic [7:0] c, input logic n);
      chk("R3", "done", done, 1);
      chk(req, "fault", fault, f);
      chk(req, "cur_sel", cur_sel, c);
      chk(req, "nt_flag", nt_flag, n);
   endtask

   task automatic t_reset;
      chk("R1", "cur_sel", cur_sel, 0);
      chk("R1", "nt_flag", nt_flag, 0);
      chk("R1", "done", done, 0);
      peek(0); chk("R2", "type0 busy wide", rd_type, 4'hB);
      chk("R2", "type0 busy narrow", n_rd_type, 4'h3);
      chk("R1", "link0", rd_link, 0);
      peek(5); chk("R2", "type5 avail wide", rd_type, 4'h9);
      chk("R2", "type5 avail narrow", n_rd_type, 4'h1);
      chk("R1", "saved nt5", rd_nt, 0);
   endtask

   task automatic t_jump;
      send(JMP, 8'd1, 4'h0);
      outcome("R4", 0, 8'd1, 0);
      peek(0); chk("R4", "type0 after leave", rd_type, 4'h9);
      chk("R2", "narrow type0 after leave", n_rd_type, 4'h1);
      chk("R4", "link0 unchanged", rd_link, 0);
      peek(1); chk("R4", "type1 entered", rd_type, 4'hB);
      chk("R2", "narrow type1 entered", n_rd_type, 4'h3);
   endtask

   task automatic t_call_chain;
      send(CALL, 8'd2, 4'h0);
      outcome("R5", 0, 8'd2, 1);
      peek(1); chk("R5", "caller stays busy", rd_type, 4'hB);
      chk("R12", "saved nt1", rd_nt, 0);
      peek(2); chk("R5", "type2", rd_type, 4'hB);
      chk("R5", "link2", rd_link, 8'd1);
      send(CALL, 8'd3, 4'h0);
      outcome("R5", 0, 8'd3, 1);
      peek(3); chk("R5", "link3", rd_link, 8'd2);
      peek(2); chk("R12", "saved nt2", rd_nt, 1);
   endtask

   task automatic t_refuse;
      send(CALL, 8'd1, 4'h0);
      outcome("R8", 1, 8'd3, 1);
      peek(1); chk("R8", "type1 untouched", rd_type, 4'hB);
      send(JMP, 8'd3, 4'h0);
      outcome("R8", 1, 8'd3, 1);
      peek(3); chk("R8", "self type kept", rd_type, 4'hB);
      chk("R8", "link3 kept", rd_link, 8'd2);
      send(CALL, 8'd9, 4'h0);
      outcome("R11", 1, 8'd3, 1);
      send(JMP, 8'd200, 4'h0);
      outcome("R11", 1, 8'd3, 1);
      peek(1); chk("R11", "type1 after range fault", rd_type, 4'hB);
      peek(3); chk("R11", "saved nt3 kept", rd_nt, 0);
   endtask

   task automatic t_gate;
      send(INTR, 8'd5, 4'hE);
      outcome("R6", 1, 8'd3, 1);
      peek(5); chk("R6", "bad gate target idle", rd_type, 4'h9);
      send(INTR, 8'd4, 4'h5);
      outcome("R6", 0, 8'd4, 1);
      peek(4); chk("R6", "link4", rd_link, 8'd3);
      chk("R6", "type4", rd_type, 4'hB);
      peek(3); chk("R6", "interrupted stays busy", rd_type, 4'hB);
      chk("R12", "saved nt3", rd_nt, 1);
   endtask

   task automatic t_unwind;
      send(RET, 8'd0, 4'h0);
      outcome("R7", 0, 8'd3, 1);
      peek(4); chk("R7", "type4 freed", rd_type, 4'h9);
      chk("R7", "saved nt4 cleared", rd_nt, 0);
      peek(3); chk("R7", "returned-to busy", rd_type, 4'hB);
      send(RET, 8'd0, 4'h0);
      outcome("R9", 0, 8'd2, 1);
      peek(3); chk("R9", "type3 freed", rd_type, 4'h9);
      send(RET, 8'd0, 4'h0);
      outcome("R12", 0, 8'd1, 0);
      peek(2); chk("R9", "type2 freed", rd_type, 4'h9);
      peek(1); chk("R9", "type1 busy", rd_type, 4'hB);
   endtask

   task automatic t_idle_return;
      send(RET, 8'd0, 4'h0);
      outcome("R10", 0, 8'd1, 0);
      peek(1); chk("R10", "type1 kept", rd_type, 4'hB);
      peek(0); chk("R10", "type0 kept", rd_type, 4'h9);
   endtask

   task automatic t_jump_saves_nt;
      send(CALL, 8'd6, 4'h0);
      outcome("R5", 0, 8'd6, 1);
      send(JMP, 8'd7, 4'h0);
      outcome("R4", 0, 8'd7, 0);
      peek(6); chk("R12", "saved nt6 from jump", rd_nt, 1);
      chk("R4", "type6 freed", rd_type, 4'h9);
      peek(7); chk("R4", "link7 untouched", rd_link, 0);
      peek(1); chk("R4", "caller 1 still busy", rd_type, 4'hB);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_jump();
      t_call_chain();
      t_refuse();
      t_gate();
      t_unwind();
      t_idle_return();
      t_jump_saves_nt();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all requirements: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule